// File: doc/BRIEF.md
# Streaming Two-Run Bitonic Merger

This block takes two input streams, each already sorted in ascending key order, and produces one ascending output stream holding every element of both. Each input beat carries H = T/2 lanes, and each lane holds a key with a value that travels alongside it. The block keeps a window of T elements in registers. It sorts that window with a bitonic merge network, emits the lower half as one output beat, and keeps the upper half. It then refills the lower half with one beat taken from the input that must supply the next keys.

Refill is decided per beat, not per element. The block compares the largest key of the last beat taken from A with the largest key of the last beat taken from B, and takes the next beat from the side whose maximum is smaller. So the same compare-exchange network serves every round. A stream may end on a partial beat: lanes beyond the beat's count become sentinel elements that sort above every real key and are never marked valid at the output. When both inputs are used up, one extra pass flushes the retained half as the final beat.

Top module: `bitonic_stream_merger`

## Requirements
- R1: After reset o_valid is 0, a_ready is 1 and b_ready is 0. The first beat of a merge is always taken from A, and only after it is the first beat of B taken.
- R2: The kept output lanes, read beat by beat with lane 0 first, form the ascending merge of all real keys of both inputs. Within a beat, kept keys do not decrease.
- R3: After the two start beats, each further beat comes from A when a_max <= b_max and otherwise from B. a_max is taken from the latest A beat: if that beat had its last flag, a_max is treated as infinite; otherwise a_max is the key of lane H-1. b_max is defined the same way for B.
- R4: a_ready and b_ready are never high together, and neither is high while o_valid is high.
- R5: Lanes i >= cnt of an input beat (cnt ranges from 1 to H; lane i sits at bits [i*32 +: 32]) are ignored. o_keep marks kept lanes as a contiguous run starting at lane 0. A real key of 32'hFFFFFFFF is kept.
- R6: Once both inputs have delivered their last beat and the current beat is accepted, one more pass runs. Its beat carries o_last = 1 and completes the stream. No earlier beat has o_last, and the block then returns to its start state.
- R7: o_valid rises exactly log2(T) cycles after the input beat or output acceptance that started the pass.
- R8: While o_valid is high and o_ready is low, o_valid, o_key, o_val, o_keep and o_last hold.
- R9: Every value leaves in the same element as the key it entered with, and each element leaves exactly once.
- R10: A compare-exchange swaps only when the key in the lower position is strictly greater. After the start beats the lower window half holds the B beat in reversed lane order. With all keys equal and one full beat per input, the output values are B lanes H-1 down to 0, then A lanes 0 up to H-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_valid | input | 1 | Input A beat present |
| a_ready | output | 1 | Input A beat taken |
| a_key | input | H*KW | Input A keys, lane i at [i*KW +: KW] |
| a_val | input | H*VW | Input A values, per lane |
| a_cnt | input | CW | Number of real lanes in the A beat (1..H) |
| a_last | input | 1 | Final beat of A |
| b_valid | input | 1 | Input B beat present |
| b_ready | output | 1 | Input B beat taken |
| b_key | input | H*KW | Input B keys |
| b_val | input | H*VW | Input B values |
| b_cnt | input | CW | Number of real lanes in the B beat |
| b_last | input | 1 | Final beat of B |
| o_valid | output | 1 | Output beat present |
| o_ready | input | 1 | Output beat taken |
| o_key | output | H*KW | Output keys, ascending by lane |
| o_val | output | H*VW | Output values |
| o_keep | output | H | Lanes holding real elements |
| o_last | output | 1 | Final beat of the merged stream |

## Verification
The hardest situation to reach is a merge in which one input runs out early while the other still holds several beats. The infinite-maximum rule must then steer every refill to the survivor, and the window at that moment mixes sentinel lanes with a retained half. The bench reaches it with deliberately skewed and unequal runs: one run lies entirely below the other, a partial last beat forces sentinels into the window, and a real all-ones key sits next to those sentinels. Each accepted input beat is checked against a source choice that the bench derives from the maxima it drove itself, and random output back-pressure stretches the passes.

// File: rtl/bitonic_stream_merger.sv
module bitonic_stream_merger #(
  parameter int T  = 8,
  parameter int KW = 32,
  parameter int VW = 32,
  localparam int H  = T / 2,
  localparam int CW = $clog2(H + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_valid,
  output logic          a_ready,
  input  logic [H*KW-1:0] a_key,
  input  logic [H*VW-1:0] a_val,
  input  logic [CW-1:0] a_cnt,
  input  logic          a_last,
  input  logic          b_valid,
  output logic          b_ready,
  input  logic [H*KW-1:0] b_key,
  input  logic [H*VW-1:0] b_val,
  input  logic [CW-1:0] b_cnt,
  input  logic          b_last,
  output logic          o_valid,
  input  logic          o_ready,
  output logic [H*KW-1:0] o_key,
  output logic [H*VW-1:0] o_val,
  output logic [H-1:0]  o_keep,
  output logic          o_last
);
  localparam int STG = $clog2(T);
  localparam int XW  = KW + 1;
  localparam int EW  = XW + VW;
  localparam int SW  = $clog2(STG + 1);

  typedef enum logic [2:0] {S_LDA, S_LDB, S_SORT, S_OUT, S_FILL} st_t;

  st_t           st;
  logic [SW-1:0] scnt;
  logic [XW-1:0] a_max, b_max, g_max;
  logic          fin, use_a, pick_a, in_fire, both_done;
  logic [CW-1:0] cnt;
  logic [EW-1:0] win [T];
  logic [EW-1:0] stg [STG][T];
  logic [EW-1:0] in_el [H];

  assign pick_a    = a_max <= b_max;
  assign use_a     = (st == S_LDA) || (st == S_FILL && pick_a);
  assign a_ready   = use_a;
  assign b_ready   = (st == S_LDB) || (st == S_FILL && !pick_a);
  assign in_fire   = (a_valid && a_ready) || (b_valid && b_ready);
  assign both_done = (&a_max) && (&b_max);
  assign cnt       = use_a ? a_cnt : b_cnt;
  assign g_max     = (use_a ? a_last : b_last) ? '1 : in_el[H-1][EW-1 -: XW];

  always_comb
    for (int i = 0; i < H; i++)
      if (i >= int'(cnt)) in_el[i] = '1;
      else if (use_a)     in_el[i] = {1'b0, a_key[i*KW +: KW], a_val[i*VW +: VW]};
      else                in_el[i] = {1'b0, b_key[i*KW +: KW], b_val[i*VW +: VW]};

  for (genvar s = 0; s < STG; s++) begin : g_stage
    localparam int D = T >> (s + 1);
    for (genvar i = 0; i < T; i++) begin : g_lane
      if ((i & D) == 0) begin : g_cx
        logic gt;
        assign gt          = win[i][EW-1 -: XW] > win[i+D][EW-1 -: XW];
        assign stg[s][i]   = gt ? win[i+D] : win[i];
        assign stg[s][i+D] = gt ? win[i]   : win[i+D];
      end
    end
  end

  always_ff @(posedge clk)
    case (st)
      S_LDA:  if (a_valid) for (int i = 0; i < H; i++) win[H+i] <= in_el[i];
      S_LDB,
      S_FILL: if (in_fire) for (int i = 0; i < H; i++) win[i] <= in_el[H-1-i];
      S_SORT: for (int i = 0; i < T; i++) win[i] <= stg[scnt][i];
      S_OUT:  if (o_ready && !fin && both_done) for (int i = 0; i < H; i++) win[i] <= '1;
      default: ;
    endcase

  always_ff @(posedge clk)
    if (!rst_n) begin
      st    <= S_LDA;
      scnt  <= '0;
      a_max <= '0;
      b_max <= '0;
      fin   <= 1'b0;
    end else
      case (st)
        S_LDA: if (a_valid) begin
          a_max <= g_max;
          st    <= S_LDB;
        end
        S_LDB: if (b_valid) begin
          b_max <= g_max;
          scnt  <= '0;
          st    <= S_SORT;
        end
        S_FILL: if (in_fire) begin
          if (use_a) a_max <= g_max;
          else       b_max <= g_max;
          scnt <= '0;
          st   <= S_SORT;
        end
        S_SORT: if (scnt == SW'(STG - 1)) st <= S_OUT;
                else scnt <= scnt + 1'b1;
        S_OUT: if (o_ready) begin
          if (fin) begin
            fin <= 1'b0;
            st  <= S_LDA;
          end else if (both_done) begin
            fin  <= 1'b1;
            scnt <= '0;
            st   <= S_SORT;
          end else st <= S_FILL;
        end
        default: st <= S_LDA;
      endcase

  assign o_valid = st == S_OUT;
  assign o_last  = fin;

  for (genvar i = 0; i < H; i++) begin : g_out
    assign o_key[i*KW +: KW] = win[i][VW +: KW];
    assign o_val[i*VW +: VW] = win[i][VW-1:0];
    assign o_keep[i]         = ~win[i][EW-1];
  end
endmodule

// File: rtl/bsm_checker.sv
module bsm_checker #(
  parameter int T  = 8,
  parameter int KW = 32,
  localparam int H = T / 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          a_valid,
  input logic          a_ready,
  input logic          b_valid,
  input logic          b_ready,
  input logic          o_valid,
  input logic          o_ready,
  input logic [H*KW-1:0] o_key,
  input logic [H-1:0]  o_keep,
  input logic          o_last
);
  localparam int STG = $clog2(T);

  logic [7:0]    gap;
  logic [KW-1:0] prev_max, top_key;
  logic          seen, beat_ok;
  logic [H-1:0]  keep_inc;

  assign keep_inc = o_keep + 1'b1;

  always_comb begin
    beat_ok = 1'b1;
    top_key = '0;
    for (int i = 0; i < H - 1; i++)
      if (o_keep[i+1] && o_key[i*KW +: KW] > o_key[(i+1)*KW +: KW]) beat_ok = 1'b0;
    for (int i = 0; i < H; i++)
      if (o_keep[i]) top_key = o_key[i*KW +: KW];
  end

  always_ff @(posedge clk)
    if (!rst_n) begin
      gap      <= '0;
      seen     <= 1'b0;
      prev_max <= '0;
    end else begin
      if ((a_valid && a_ready) || (b_valid && b_ready) || (o_valid && o_ready)) gap <= '0;
      else if (gap != 8'hFF) gap <= gap + 1'b1;
      if (o_valid && o_ready) begin
        if (o_last) seen <= 1'b0;
        else if (|o_keep) begin
          seen     <= 1'b1;
          prev_max <= top_key;
        end
      end
    end

  AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_ready && b_ready)); // R4
  AST_NO_FETCH_WHILE_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    o_valid |-> !a_ready && !b_ready); // R4
  AST_KEEP_LOW_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    o_valid |-> (o_keep & keep_inc) == '0); // R5
  AST_BEAT_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
    o_valid |-> beat_ok); // R2
  AST_STREAM_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
    o_valid && o_keep[0] && seen |-> o_key[KW-1:0] >= prev_max); // R2
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    o_valid && !o_ready |=> o_valid && $stable(o_key) && $stable(o_keep) && $stable(o_last)); // R8
  AST_PASS_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(o_valid) |-> gap == 8'(STG)); // R7
endmodule

bind bitonic_stream_merger bsm_checker #(.T(T), .KW(KW)) u_bsm_chk (
  .clk(clk), .rst_n(rst_n),
  .a_valid(a_valid), .a_ready(a_ready),
  .b_valid(b_valid), .b_ready(b_ready),
  .o_valid(o_valid), .o_ready(o_ready),
  .o_key(o_key), .o_keep(o_keep), .o_last(o_last)
);

// File: tb/bitonic_stream_merger_tb_top.sv
module bitonic_stream_merger_tb_top;
  localparam int T = 8, H = 4, KW = 32, VW = 32, CW = 3, STG = 3;

  logic clk = 0, rst_n = 0;
  logic a_valid = 0, b_valid = 0, a_last = 0, b_last = 0, o_ready = 0;
  logic a_ready, b_ready, o_valid, o_last;
  logic [H*KW-1:0] a_key = '0, b_key = '0, o_key;
  logic [H*VW-1:0] a_val = '0, b_val = '0, o_val;
  logic [CW-1:0] a_cnt = '0, b_cnt = '0;
  logic [H-1:0] o_keep;

  bitonic_stream_merger #(.T(T), .KW(KW), .VW(VW)) dut_i (.*);

  always #5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [31:0] ka [64], kb [64];
  logic [31:0] got_k [128], got_v [128];
  int na, nb, nout, loads, last_fire;
  logic [32:0] m_a, m_b;

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  always @(posedge clk)
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: run hung act=%0d exp<150000", cyc);
      report();
    end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive_a();
    for (int s = 0; s < na; s += H) begin
      int n = (na - s < H) ? na - s : H;
      for (int l = 0; l < H; l++) begin
        a_key[l*KW +: KW] = (l < n) ? ka[s+l] : 32'h0;
        a_val[l*VW +: VW] = (l < n) ? (32'h000A_0000 | 32'(s + l)) : 32'hDEAD_BEEF;
      end
      a_cnt = CW'(n); a_last = (s + H >= na); a_valid = 1;
      while (!a_ready) @(negedge clk);
      if (loads >= 2) chk(m_a <= m_b, "R3", "refill taken from A", 64'(m_a), 64'(m_b));
      else chk(loads == 0, "R1", "A start beat first", 64'(loads), 0);
      m_a = a_last ? '1 : {1'b0, a_key[(H-1)*KW +: KW]};
      loads++; last_fire = cyc;
      @(negedge clk);
    end
    a_valid = 0;
  endtask

  task automatic drive_b();
    for (int s = 0; s < nb; s += H) begin
      int n = (nb - s < H) ? nb - s : H;
      for (int l = 0; l < H; l++) begin
        b_key[l*KW +: KW] = (l < n) ? kb[s+l] : 32'h0;
        b_val[l*VW +: VW] = (l < n) ? (32'h000B_0000 | 32'(s + l)) : 32'hDEAD_BEEF;
      end
      b_cnt = CW'(n); b_last = (s + H >= nb); b_valid = 1;
      while (!b_ready) @(negedge clk);
      if (loads >= 2) chk(!(m_a <= m_b), "R3", "refill taken from B", 64'(m_a), 64'(m_b));
      else chk(loads == 1, "R1", "B start beat after A", 64'(loads), 1);
      m_b = b_last ? '1 : {1'b0, b_key[(H-1)*KW +: KW]};
      loads++; last_fire = cyc;
      @(negedge clk);
    end
    b_valid = 0;
  endtask

  task automatic sink(input bit rnd);
    bit prev_ov = 0, hold = 0, done = 0;
    logic [H*KW-1:0] hk;
    logic [H*VW-1:0] hv;
    logic [H-1:0] hkeep, kinc;
    while (!done) begin
      o_ready = rnd ? ($urandom % 3 != 0) : 1'b1;
      if (hold) begin
        chk(o_valid && o_key == hk && o_val == hv && o_keep == hkeep, "R8",
            "stalled beat held", 64'(o_keep), 64'(hkeep));
      end
      if (o_valid && !prev_ov)
        chk(cyc - last_fire == STG + 1, "R7", "pass latency", 64'(cyc - last_fire - 1), STG);
      prev_ov = o_valid;
      hold = o_valid && !o_ready; hk = o_key; hv = o_val; hkeep = o_keep;
      if (o_valid && o_ready) begin
        kinc = o_keep + 1'b1;
        chk((o_keep & kinc) == '0, "R5", "keep is low contiguous", 64'(o_keep), 0);
        for (int l = 0; l < H; l++)
          if (o_keep[l] && nout < 128) begin
            got_k[nout] = o_key[l*KW +: KW];
            got_v[nout] = o_val[l*VW +: VW];
            nout++;
          end
        if (o_last) done = 1;
        last_fire = cyc;
      end
      @(negedge clk);
    end
    o_ready = 0;
  endtask

  task automatic run_merge(input bit rnd);
    logic [31:0] r [128];
    int sa [64], sb [64];
    int n = na + nb;
    loads = 0; nout = 0; m_a = '0; m_b = '0;
    fork
      drive_a();
      drive_b();
      sink(rnd);
    join
    chk(nout == n, "R6", "elements before last beat", 64'(nout), 64'(n));
    chk(a_ready && !b_ready && !o_valid, "R6", "back to start state",
        {62'b0, a_ready, b_ready}, 64'h2);
    for (int i = 0; i < na; i++) r[i] = ka[i];
    for (int i = 0; i < nb; i++) r[na+i] = kb[i];
    for (int i = 1; i < n; i++) begin
      logic [31:0] t = r[i];
      int j = i - 1;
      while (j >= 0 && r[j] > t) begin r[j+1] = r[j]; j--; end
      r[j+1] = t;
    end
    for (int i = 0; i < 64; i++) begin sa[i] = 0; sb[i] = 0; end
    for (int i = 0; i < nout && i < n; i++) begin
      int idx = int'(got_v[i][15:0]);
      chk(got_k[i] == r[i], "R2", "merged key order", 64'(got_k[i]), 64'(r[i]));
      if (got_v[i][31:16] == 16'h000A && idx < na) begin
        sa[idx]++;
        chk(got_k[i] == ka[idx], "R9", "A value stays with key", 64'(got_k[i]), 64'(ka[idx]));
      end else if (got_v[i][31:16] == 16'h000B && idx < nb) begin
        sb[idx]++;
        chk(got_k[i] == kb[idx], "R9", "B value stays with key", 64'(got_k[i]), 64'(kb[idx]));
      end else chk(0, "R9", "unknown value emitted", 64'(got_v[i]), 0);
    end
    for (int i = 0; i < na; i++) chk(sa[i] == 1, "R9", "A element once", 64'(sa[i]), 1);
    for (int i = 0; i < nb; i++) chk(sb[i] == 1, "R9", "B element once", 64'(sb[i]), 1);
  endtask

  task automatic t_reset();
    chk(!o_valid, "R1", "o_valid after reset", 64'(o_valid), 0);
    chk(a_ready, "R1", "a_ready after reset", 64'(a_ready), 1);
    chk(!b_ready, "R1", "b_ready after reset", 64'(b_ready), 0);
  endtask

  task automatic t_all_equal();
    na = 4; nb = 4;
    for (int i = 0; i < 4; i++) begin ka[i] = 32'd7; kb[i] = 32'd7; end
    run_merge(0);
    for (int i = 0; i < 8; i++) begin
      logic [31:0] e = (i < 4) ? (32'h000B_0000 | 32'(3 - i)) : (32'h000A_0000 | 32'(i - 4));
      chk(got_v[i] == e, "R10", "equal keys keep position", 64'(got_v[i]), 64'(e));
    end
  endtask

  task automatic t_interleaved();
    na = 12; nb = 12;
    for (int i = 0; i < 12; i++) begin ka[i] = 32'(2 * i); kb[i] = 32'(2 * i + 1); end
    run_merge(1);
  endtask

  task automatic t_unequal_random();
    logic [31:0] k = 0;
    na = 13; nb = 6;
    for (int i = 0; i < na; i++) begin k += $urandom % 4; ka[i] = k; end
    ka[na-1] = 32'hFFFF_FFFF;
    k = 5;
    for (int i = 0; i < nb; i++) begin k += $urandom % 7; kb[i] = k; end
    kb[nb-1] = 32'hFFFF_FFFF;
    run_merge(1);
    chk(got_k[na+nb-1] == 32'hFFFF_FFFF && got_k[na+nb-2] == 32'hFFFF_FFFF, "R5",
        "all-ones keys kept", 64'(got_k[na+nb-2]), 64'hFFFF_FFFF);
  endtask

  task automatic t_skewed();
    na = 9; nb = 5;
    for (int i = 0; i < na; i++) ka[i] = 32'(3 * i);
    for (int i = 0; i < nb; i++) kb[i] = 32'(1000 + i);
    run_merge(0);
  endtask

  task automatic t_tiny();
    na = 1; nb = 2;
    ka[0] = 32'd50; kb[0] = 32'd10; kb[1] = 32'd90;
    run_merge(1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_all_equal();
    t_interleaved();
    t_unequal_random();
    t_skewed();
    t_tiny();
    repeat (4) @(negedge clk);
    report();
  end
endmodule